// File: doc/BRIEF.md
# Stereo one-bit stream receiver with channel select

This block takes a stereo one-bit density-modulated audio stream that shares a single data wire and turns it into one mono sample stream for a downstream modulator. Both the bit clock and the data wire are brought into the system clock domain through synchronizer flops. Edges of the bit clock are then found in that domain. The data seen at a rising edge is the left bit, and the data seen at the next falling edge is the right bit. A two-bit mode input picks one of four outputs: the left channel, the right channel, the average of the two, or silence.

Alongside the audio path, a rate monitor counts rising bit-clock edges over a fixed window of system cycles. It classifies the rate as low band, high band or unsupported. Averaging is not allowed in the high band. If it is requested there, the block raises an error flag and outputs the left channel instead. A presence flag drops when the bit clock has stopped, so that a controller can put the amplifier into standby. The system clock must run at least eight times faster than the bit clock.

Top module: `pdm_stereo_rx`

## Requirements
- R1: The data bit seen at a rising bit-clock edge is the left bit, and the one seen at the following falling edge is the right bit. Exactly one output sample with a one-cycle `sample_vld_o` strobe is produced per bit-clock period, after the right bit is taken.
- R2: The mode codes are 2'b00 silence, 2'b01 left, 2'b10 right and 2'b11 average. In silence, `sample_vld_o` stays low and `sample_o` stays 2'b00 whatever the data wire carries.
- R3: In left mode, each sample is +1 for a left bit of 1 and -1 for a left bit of 0. Right bits have no effect.
- R4: In right mode, each sample is +1 or -1 from the right bit. Left bits have no effect.
- R5: In average mode, the sample is (L+R)/2 with each bit mapped to +1 or -1, giving +1, 0 or -1. `sample_o` is two's complement: 2'b01 is +1, 2'b11 is -1, 2'b00 is 0, and 2'b10 never appears.
- R6: Rising bit-clock edges are counted in every window of `WIN_CYCLES` system cycles. At the end of a window, `rate_err_o` is set if the count is outside both [`LO_MIN`,`LO_MAX`] and [`HI_MIN`,`HI_MAX`]. It is cleared after a window whose count is inside either band.
- R7: When average mode is selected and the last completed window was in the high band, `mode_err_o` is 1 and samples follow the left channel as in R3. In the low band, `mode_err_o` is 0.
- R8: `clk_present_o` is 0 after reset and becomes 0 once `LOSS_CYCLES` system cycles pass with no bit-clock edge. It becomes 1 within a few system cycles of a bit-clock edge.
- R9: While reset is held, `sample_o`, `sample_vld_o`, `mode_err_o`, `rate_err_o` and `clk_present_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pdm_clk_i | input | 1 | Bit clock of the stereo stream (asynchronous) |
| pdm_dat_i | input | 1 | Shared one-bit data wire |
| mode_i | input | 2 | Output mode: 00 silence, 01 left, 10 right, 11 average |
| sample_o | output | 2 | Mono sample, two's complement in {-1,0,+1} |
| sample_vld_o | output | 1 | One-cycle strobe per new sample |
| mode_err_o | output | 1 | Average requested in the high rate band |
| rate_err_o | output | 1 | Last measured rate outside both bands |
| clk_present_o | output | 1 | Bit clock has toggled recently |

## Verification
A slip in the edge pairing, such as a left/right swap or a frame taken across two periods, shows up as a wrong sign on the very first checked sample after the edge. It also changes the number of strobes counted per phase. A stale band classification shows up only at a window boundary, up to `WIN_CYCLES` cycles late, as a wrong `mode_err_o` or `rate_err_o`, and as average-mode samples that quietly follow the left channel. A broken idle counter shows at `clk_present_o` either `LOSS_CYCLES` cycles after the clock stops or at the first edge after a restart.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LEFT  = 2'b01,
        MODE_RIGHT = 2'b10,
        MODE_MIX   = 2'b11
    } pdm_mode_e;

    typedef logic signed [1:0] pcm2_t;

    localparam pcm2_t PCM_POS  = 2'sb01;
    localparam pcm2_t PCM_NEG  = 2'sb11;
    localparam pcm2_t PCM_ZERO = 2'sb00;

    // one bit of density stream to a signed unit level
    function automatic pcm2_t bit_to_pcm(input logic b);
        return b ? PCM_POS : PCM_NEG;
    endfunction

    // half sum of two unit levels
    function automatic pcm2_t mix_pcm(input logic l, input logic r);
        return (l == r) ? bit_to_pcm(l) : PCM_ZERO;
    endfunction

endpackage

// File: rtl/pdm_edge_capture.sv
module pdm_edge_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdm_clk_i,
    input  logic pdm_dat_i,
    output logic rise_o,
    output logic fall_o,
    output logic frame_vld_o,
    output logic left_bit_o,
    output logic right_bit_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] ck_sync;
        logic [SYNC_STAGES-1:0] dt_sync;
        logic                   ck_prev;
        logic                   have_left;
        logic                   left_bit;
        logic                   right_bit;
        logic                   frame_vld;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic ck_s, dt_s, rise, fall;

    assign ck_s = st_q.ck_sync[SYNC_STAGES-1];
    assign dt_s = st_q.dt_sync[SYNC_STAGES-1];
    assign rise = ck_s & ~st_q.ck_prev;
    assign fall = ~ck_s & st_q.ck_prev;

    always_comb begin
        st_d           = st_q;
        st_d.ck_sync   = {st_q.ck_sync[SYNC_STAGES-2:0], pdm_clk_i};
        st_d.dt_sync   = {st_q.dt_sync[SYNC_STAGES-2:0], pdm_dat_i};
        st_d.ck_prev   = ck_s;
        st_d.frame_vld = 1'b0;
        if (rise) begin
            st_d.left_bit  = dt_s;
            st_d.have_left = 1'b1;
        end
        if (fall) begin
            st_d.right_bit = dt_s;
            st_d.frame_vld = st_q.have_left;
            st_d.have_left = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o      = rise;
    assign fall_o      = fall;
    assign frame_vld_o = st_q.frame_vld;
    assign left_bit_o  = st_q.left_bit;
    assign right_bit_o = st_q.right_bit;

    // a frame closes on a falling edge, so two frames never come back to back
    assert_frame_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |=> !frame_vld_o);

    // a frame is only emitted once a left bit has been taken in this period
    assert_frame_has_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |-> !st_q.have_left);

endmodule

// File: rtl/pdm_rate_monitor.sv
module pdm_rate_monitor #(
    parameter int WIN_CYCLES  = 1000,
    parameter int LO_MIN      = 18,
    parameter int LO_MAX      = 44,
    parameter int HI_MIN      = 52,
    parameter int HI_MAX      = 87,
    parameter int LOSS_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic edge_i,
    output logic hi_band_o,
    output logic rate_err_o,
    output logic clk_present_o
);

    localparam int WIN_W  = $clog2(WIN_CYCLES);
    localparam int CNT_W  = $clog2(WIN_CYCLES + 1);
    localparam int LOSS_W = $clog2(LOSS_CYCLES + 1);

    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [LOSS_W-1:0] LOSS_LIM = LOSS_W'(LOSS_CYCLES);

    typedef struct packed {
        logic [WIN_W-1:0]  win_cnt;
        logic [CNT_W-1:0]  edge_cnt;
        logic              hi_band;
        logic              rate_err;
        logic [LOSS_W-1:0] idle_cnt;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic [CNT_W-1:0] total;
    logic in_lo, in_hi;

    assign total = st_q.edge_cnt + CNT_W'(rise_i);
    assign in_lo = (total >= CNT_W'(LO_MIN)) && (total <= CNT_W'(LO_MAX));
    assign in_hi = (total >= CNT_W'(HI_MIN)) && (total <= CNT_W'(HI_MAX));

    always_comb begin
        st_d = st_q;
        if (st_q.win_cnt == WIN_LAST) begin
            st_d.win_cnt  = '0;
            st_d.edge_cnt = '0;
            st_d.hi_band  = in_hi;
            st_d.rate_err = !(in_lo || in_hi);
        end else begin
            st_d.win_cnt  = st_q.win_cnt + 1'b1;
            st_d.edge_cnt = total;
        end
        if (edge_i)                     st_d.idle_cnt = '0;
        else if (st_q.idle_cnt < LOSS_LIM) st_d.idle_cnt = st_q.idle_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.idle_cnt <= LOSS_LIM;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_band_o     = st_q.hi_band;
    assign rate_err_o    = st_q.rate_err;
    assign clk_present_o = (st_q.idle_cnt < LOSS_LIM);

    // a rate cannot be both an accepted high band and unsupported
    assert_band_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_band_o && rate_err_o));

    // presence only returns after an observed bit-clock edge
    assert_present_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_present_o) |-> $past(edge_i));

endmodule

// File: rtl/pdm_chan_mixer.sv
module pdm_chan_mixer
    import pdm_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pdm_mode_e mode_i,
    input  logic      hi_band_i,
    input  logic      frame_vld_i,
    input  logic      left_bit_i,
    input  logic      right_bit_i,
    output logic [1:0] sample_o,
    output logic      sample_vld_o,
    output logic      mode_err_o
);

    typedef struct packed {
        pcm2_t sample;
        logic  vld;
        logic  mode_err;
    } mix_state_t;

    mix_state_t st_d, st_q;
    pdm_mode_e  eff_mode;
    logic       mix_refused;

    assign mix_refused = (mode_i == MODE_MIX) && hi_band_i;
    assign eff_mode    = mix_refused ? MODE_LEFT : mode_i;

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.mode_err = mix_refused;
        case (eff_mode)
            MODE_OFF: st_d.sample = PCM_ZERO;
            MODE_LEFT: if (frame_vld_i) begin
                st_d.sample = bit_to_pcm(left_bit_i);
                st_d.vld    = 1'b1;
            end
            MODE_RIGHT: if (frame_vld_i) begin
                st_d.sample = bit_to_pcm(right_bit_i);
                st_d.vld    = 1'b1;
            end
            default: if (frame_vld_i) begin
                st_d.sample = mix_pcm(left_bit_i, right_bit_i);
                st_d.vld    = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o     = st_q.sample;
    assign sample_vld_o = st_q.vld;
    assign mode_err_o   = st_q.mode_err;

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> (sample_o == 2'b00 && !sample_vld_o));

    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != 2'b10);

    assert_vld_from_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> $past(frame_vld_i));

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
    import pdm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYCLES  = 1000,
    parameter int LO_MIN      = 18,
    parameter int LO_MAX      = 44,
    parameter int HI_MIN      = 52,
    parameter int HI_MAX      = 87,
    parameter int LOSS_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdm_clk_i,
    input  logic       pdm_dat_i,
    input  logic [1:0] mode_i,
    output logic [1:0] sample_o,
    output logic       sample_vld_o,
    output logic       mode_err_o,
    output logic       rate_err_o,
    output logic       clk_present_o
);

    logic rise, fall, frame_vld, left_bit, right_bit, hi_band;

    pdm_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .pdm_clk_i   (pdm_clk_i),
        .pdm_dat_i   (pdm_dat_i),
        .rise_o      (rise),
        .fall_o      (fall),
        .frame_vld_o (frame_vld),
        .left_bit_o  (left_bit),
        .right_bit_o (right_bit)
    );

    pdm_rate_monitor #(
        .WIN_CYCLES  (WIN_CYCLES),
        .LO_MIN      (LO_MIN),
        .LO_MAX      (LO_MAX),
        .HI_MIN      (HI_MIN),
        .HI_MAX      (HI_MAX),
        .LOSS_CYCLES (LOSS_CYCLES)
    ) u_rate (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_i        (rise),
        .edge_i        (rise | fall),
        .hi_band_o     (hi_band),
        .rate_err_o    (rate_err_o),
        .clk_present_o (clk_present_o)
    );

    pdm_chan_mixer u_mix (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (pdm_mode_e'(mode_i)),
        .hi_band_i    (hi_band),
        .frame_vld_i  (frame_vld),
        .left_bit_i   (left_bit),
        .right_bit_i  (right_bit),
        .sample_o     (sample_o),
        .sample_vld_o (sample_vld_o),
        .mode_err_o   (mode_err_o)
    );

    // the refusal flag only follows a high-band classification
    assert_mode_err_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> $past(hi_band));

endmodule

// File: tb/sim_pdm_stereo_rx.sv
module sim_pdm_stereo_rx;

    localparam int WIN  = 1000;
    localparam int LMIN = 18, LMAX = 44, HMIN = 52, HMAX = 87;
    localparam int LOSS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdm_clk = 1'b0;
    logic pdm_dat = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] sample_o;
    logic sample_vld_o, mode_err_o, rate_err_o, clk_present_o;

    always #10 clk = ~clk;

    pdm_stereo_rx #(
        .WIN_CYCLES(WIN), .LO_MIN(LMIN), .LO_MAX(LMAX),
        .HI_MIN(HMIN), .HI_MAX(HMAX), .LOSS_CYCLES(LOSS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pdm_clk_i(pdm_clk), .pdm_dat_i(pdm_dat),
        .mode_i(mode), .sample_o(sample_o), .sample_vld_o(sample_vld_o),
        .mode_err_o(mode_err_o), .rate_err_o(rate_err_o), .clk_present_o(clk_present_o)
    );

    int checks = 0, errs = 0;
    int mon_checks = 0, mon_errs = 0, off_bad = 0;
    int wr = 0, rd = 0;
    logic [1:0] exp_mem [0:255];
    logic chk_en = 1'b0;
    logic [1:0] cur_mode = 2'b00;
    string tag = "";

    // expected sample from R3/R4/R5/R7
    function automatic logic [1:0] ref_sample(input logic [1:0] m, input logic hi,
                                              input logic l, input logic r);
        logic [1:0] eff;
        eff = (m == 2'b11 && hi) ? 2'b01 : m;
        case (eff)
            2'b01:   return l ? 2'b01 : 2'b11;
            2'b10:   return r ? 2'b01 : 2'b11;
            default: return (l == r) ? (l ? 2'b01 : 2'b11) : 2'b00;
        endcase
    endfunction

    // band from R6: rising edges per window for a half period of h cycles
    function automatic int band_of(input int h);
        int n;
        n = WIN / (2 * h);
        if (n >= LMIN && n <= LMAX) return 0;
        if (n >= HMIN && n <= HMAX) return 1;
        return 2;
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic exp_hi = 1'b0;

    // one bit-clock period, half period h system cycles (h even)
    task automatic drive_frame(input int h, input logic l, input logic r);
        pdm_dat = l;
        wait_n(h / 2);
        pdm_clk = 1'b1;
        wait_n(h / 2);
        pdm_dat = r;
        wait_n(h / 2);
        pdm_clk = 1'b0;
        if (chk_en && cur_mode != 2'b00) begin
            exp_mem[wr % 256] = ref_sample(cur_mode, exp_hi, l, r);
            wr++;
        end
        wait_n(h / 2);
    endtask

    task automatic run_phase(input logic [1:0] m, input int h, input int nchk, input string lbl);
        int warm;
        int off0;
        warm = 2400 / (2 * h) + 2;
        mode = m;
        for (int i = 0; i < warm; i++) drive_frame(h, 1'($urandom), 1'($urandom));
        wait_n(12);
        cur_mode = m;
        exp_hi = (band_of(h) == 1);
        tag = lbl;
        off0 = off_bad;
        chk_en = 1'b1;
        for (int i = 0; i < nchk; i++) drive_frame(h, 1'($urandom), 1'($urandom));
        wait_n(12);
        chk_en = 1'b0;
        if (m != 2'b00)
            check(rd == wr, {lbl, " R1 one strobe per period"}, rd, wr);
        else begin
            check(off_bad == off0, "R2 silence: strobes or nonzero samples", off_bad - off0, 0);
            check(sample_o == 2'b00, "R2 silence sample", int'(sample_o), 0);
        end
        if (m == 2'b11)
            check(mode_err_o == exp_hi, {lbl, " R7 mode_err"}, int'(mode_err_o), int'(exp_hi));
        check(rate_err_o == 1'b0, {lbl, " R6 in-band rate_err"}, int'(rate_err_o), 0);
    endtask

    task automatic rate_phase(input int h, input logic expect_err);
        int n;
        mode = 2'b01;
        n = 2400 / (2 * h) + 2;
        for (int i = 0; i < n; i++) drive_frame(h, 1'($urandom), 1'($urandom));
        check(rate_err_o == expect_err, $sformatf("R6 rate_err half period %0d", h),
              int'(rate_err_o), int'(expect_err));
    endtask

    // output monitor
    always @(negedge clk) begin
        if (chk_en && sample_vld_o) begin
            if (cur_mode == 2'b00) off_bad++;
            else begin
                mon_checks++;
                if (rd >= wr || sample_o !== exp_mem[rd % 256]) begin
                    mon_errs++;
                    $display("FAIL %s sample %0d: got %b expected %b", tag, rd, sample_o,
                             exp_mem[rd % 256]);
                end
                rd++;
            end
        end
        if (chk_en && cur_mode == 2'b00 && sample_o !== 2'b00) off_bad++;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired: got hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errs + mon_errs + 1);
        $finish;
    end

    initial begin
        logic [1:0] rm;
        int rh;
        void'($urandom(32'd2024));
        wait_n(5);
        check(sample_o == 2'b00, "R9 reset sample", int'(sample_o), 0);
        check(sample_vld_o == 1'b0, "R9 reset strobe", int'(sample_vld_o), 0);
        check(mode_err_o == 1'b0, "R9 reset mode_err", int'(mode_err_o), 0);
        check(rate_err_o == 1'b0, "R9 reset rate_err", int'(rate_err_o), 0);
        check(clk_present_o == 1'b0, "R9 R8 reset presence", int'(clk_present_o), 0);
        rst_n = 1'b1;
        wait_n(3);

        // directed modes
        run_phase(2'b01, 12, 40, "R3 left low band");
        run_phase(2'b10, 8,  40, "R4 right high band");
        run_phase(2'b11, 16, 40, "R5 average low band");
        run_phase(2'b11, 6,  40, "R7 average refused high band");
        run_phase(2'b00, 12, 20, "R2 silence");
        // corner: all-ones / all-zeros / opposite bits in average mode
        mode = 2'b11;
        cur_mode = 2'b11; exp_hi = 1'b0; tag = "R5 average corners";
        for (int i = 0; i < 300; i++) drive_frame(12, 1'b0, 1'b0);
        wait_n(12);
        chk_en = 1'b1;
        drive_frame(12, 1'b1, 1'b1);
        drive_frame(12, 1'b0, 1'b0);
        drive_frame(12, 1'b1, 1'b0);
        drive_frame(12, 1'b0, 1'b1);
        wait_n(12);
        chk_en = 1'b0;
        check(rd == wr, "R5 corner strobes", rd, wr);

        // unsupported rates and recovery
        rate_phase(10, 1'b1);
        rate_phase(40, 1'b1);
        rate_phase(4,  1'b1);
        rate_phase(12, 1'b0);

        // random modes and rates
        for (int k = 0; k < 6; k++) begin
            rm = 2'($urandom_range(3, 1));
            case ($urandom_range(3, 0))
                0: rh = 6;
                1: rh = 8;
                2: rh = 12;
                default: rh = 16;
            endcase
            run_phase(rm, rh, 30, $sformatf("R3 R4 R5 random mode %0d", rm));
        end

        // clock loss and return
        wait_n(LOSS + 20);
        check(clk_present_o == 1'b0, "R8 presence after stop", int'(clk_present_o), 0);
        drive_frame(8, 1'b1, 1'b0);
        check(clk_present_o == 1'b1, "R8 presence after restart", int'(clk_present_o), 1);

        wait_n(5);
        $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
        $finish;
    end

endmodule